// File: doc/BRIEF.md
# Coherent Store Buffer with Load Forwarding

This block sits in one core between its store port and its private coherent data cache. If the cache reports that a store's line is already held with write permission (exclusive or modified), the store writes the cache directly in the same cycle. Any other store is parked in a small in-order queue. In the cycle the store is parked, the block issues a read-invalidate request that carries the line address and the queue slot. Each peer core answers the request with an acknowledgement tagged with that slot. A parked store is written into the cache only after every peer has answered it. Parked stores leave the queue strictly in arrival order.

Loads search the queue before the cache is used. Among the queued stores to the same word that share at least one byte lane with the load, the youngest one decides the result. If it covers every byte the load asks for, the block returns its data. If it covers only some of those bytes, the load is stalled until that store leaves the queue. If no queued store overlaps, the load goes to the cache.

A barrier request, used for both full and write ordering, blocks every later store, including direct ones, until all earlier queued stores have reached the cache. A one-cycle done pulse then reports that the queue has drained.

The queue depth is a power of two. A store or an acknowledgement presented in a given cycle affects loads only from the next cycle. The cache write port accepts one write per cycle without backpressure. A line with an outstanding read-invalidate is never reported as exclusive.

Top module: `store_buffer_fwd`

## Requirements
- R1: After reset the queue is empty: `st_ready_o` is 1, and `rdinv_valid_o`, `cwr_valid_o`, `ld_hit_o`, `ld_stall_o` and `bar_done_o` are all 0.
- R2: A store accepted with `st_excl_i`=0 raises `rdinv_valid_o` in its own cycle. In that cycle `rdinv_line_o` carries the line address (store address without the low OFS_W word-offset bits) and `rdinv_idx_o` carries the slot, which counts 0,1,..,DEPTH-1 cyclically over all parked stores. The cache is not written in that cycle.
- R3: A parked store produces no cache write until N_PEER acknowledgements for its slot have been received. Its write appears on `cwr_*` in the cycle after the clock edge that captured the last acknowledgement.
- R4: Parked stores reach the cache in arrival order, even when a younger store has been fully acknowledged first.
- R5: Acknowledgements from several peers in one cycle are all counted, including in a cycle that also parks a new store.
- R6: A load returns the data of the youngest queued store to the same word whose byte mask overlaps `ld_be_i`, provided that mask covers all of `ld_be_i`. Lanes outside `ld_be_i` read as zero, and `ld_hit_o`=1.
- R7: If the youngest overlapping store covers only part of `ld_be_i`, `ld_stall_o`=1 until that store has been written to the cache.
- R8: With no barrier pending, a store with `st_excl_i`=1 writes the cache in its own cycle, ahead of older parked stores. A parked store ready in that same cycle is written in the next cycle.
- R9: With DEPTH stores parked, a store with `st_excl_i`=0 sees `st_ready_o`=0 and issues no request, while a store with `st_excl_i`=1 is still accepted.
- R10: From the cycle after `bar_i`, every store sees `st_ready_o`=0 until the queue is empty. `bar_done_o` is 1 for exactly the first cycle in which the queue is empty, and stores are accepted again in that cycle.
- R11: A load with no overlapping queued store gives `ld_hit_o`=0 and `ld_stall_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | LINE_W+OFS_W | Store word address, {line, word offset} |
| st_data_i | input | DATA_W | Store data |
| st_be_i | input | DATA_W/8 | Store byte mask |
| st_excl_i | input | 1 | The store's line is held with write permission |
| st_ready_o | output | 1 | Store accepted this cycle |
| rdinv_valid_o | output | 1 | Read-invalidate request |
| rdinv_line_o | output | LINE_W | Line address of the request |
| rdinv_idx_o | output | log2(DEPTH) | Queue slot tag of the request |
| ack_vld_i | input | N_PEER | Acknowledgement valid, one bit per peer |
| ack_idx_i | input | N_PEER*log2(DEPTH) | Slot tag of each peer's acknowledgement |
| cwr_valid_o | output | 1 | Cache write |
| cwr_addr_o | output | LINE_W+OFS_W | Cache write word address |
| cwr_data_o | output | DATA_W | Cache write data |
| cwr_be_o | output | DATA_W/8 | Cache write byte mask |
| ld_valid_i | input | 1 | Load lookup |
| ld_addr_i | input | LINE_W+OFS_W | Load word address |
| ld_be_i | input | DATA_W/8 | Load byte mask |
| ld_hit_o | output | 1 | Load served from the queue |
| ld_stall_o | output | 1 | Load must wait |
| ld_data_o | output | DATA_W | Forwarded data |
| bar_i | input | 1 | Barrier request |
| bar_done_o | output | 1 | Queue drained after a barrier |

## Verification
A slot that loses an acknowledgement shows up as a cache write one or more cycles late. A slot that gains one shows up as a write before the last peer has answered. Either error appears on `cwr_valid_o` in the cycle after the last acknowledgement edge. A corrupted head or tail pointer changes the order or the address of committed writes, or the tag on `rdinv_idx_o`, and that is visible at the next commit or the next request. A stale valid bit, or a wrong age order in the search, shows at once as a wrong hit, a wrong stall or wrong forwarded lanes on a load to a word that is still queued. A barrier flag that stays set or clears early shows within a cycle of the drain as a stuck or missing `bar_done_o` or `st_ready_o`.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {LD_MISS, LD_HIT, LD_STALL} ld_res_e;

  function automatic int unsigned ring_idx(int unsigned base, int unsigned off,
                                           int unsigned depth);
    return (base + off) % depth;
  endfunction
endpackage

// File: rtl/sb_entries.sv
module sb_entries #(
  parameter int WA_W   = 30,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int N_PEER = 3,
  parameter int CNT_W  = $clog2(N_PEER + 1)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               alloc_i,
  input  logic [IDX_W-1:0]                   alloc_idx_i,
  input  logic [WA_W-1:0]                    waddr_i,
  input  logic [DATA_W-1:0]                  data_i,
  input  logic [BE_W-1:0]                    be_i,
  input  logic                               commit_i,
  input  logic [IDX_W-1:0]                   commit_idx_i,
  input  logic [N_PEER-1:0]                  ack_vld_i,
  input  logic [N_PEER*IDX_W-1:0]            ack_idx_i,
  output logic [DEPTH-1:0]                   vld_o,
  output logic [DEPTH-1:0][WA_W-1:0]         waddr_o,
  output logic [DEPTH-1:0][DATA_W-1:0]       data_o,
  output logic [DEPTH-1:0][BE_W-1:0]         be_o,
  output logic [DEPTH-1:0][CNT_W-1:0]        acks_o
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [CNT_W-1:0] dec;

    always_comb begin
      dec = '0;
      for (int p = 0; p < N_PEER; p++)
        if (ack_vld_i[p] && ack_idx_i[p*IDX_W +: IDX_W] == IDX_W'(e))
          dec = dec + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[e]   <= 1'b0;
        waddr_o[e] <= '0;
        data_o[e]  <= '0;
        be_o[e]    <= '0;
        acks_o[e]  <= '0;
      end else if (alloc_i && alloc_idx_i == IDX_W'(e)) begin
        vld_o[e]   <= 1'b1;
        waddr_o[e] <= waddr_i;
        data_o[e]  <= data_i;
        be_o[e]    <= be_i;
        acks_o[e]  <= CNT_W'(N_PEER);
      end else begin
        if (commit_i && commit_idx_i == IDX_W'(e)) vld_o[e] <= 1'b0;
        acks_o[e] <= acks_o[e] - dec;
      end
    end
  end

  for (genvar p = 0; p < N_PEER; p++) begin : g_ack_chk
    AST_ACK_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_vld_i[p] |-> vld_o[ack_idx_i[p*IDX_W +: IDX_W]] &&
                       acks_o[ack_idx_i[p*IDX_W +: IDX_W]] != '0)
      else $error("ack to idle slot"); // R5
  end

  AST_COMMIT_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> vld_o[commit_idx_i] && acks_o[commit_idx_i] == '0)
    else $error("commit before all acks"); // R3

endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
  parameter int WA_W   = 30,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]                   vld_i,
  input  logic [DEPTH-1:0][WA_W-1:0]         waddr_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]       data_i,
  input  logic [DEPTH-1:0][BE_W-1:0]         be_i,
  input  logic [IDX_W-1:0]                   head_i,
  input  logic                               ld_valid_i,
  input  logic [WA_W-1:0]                    ld_addr_i,
  input  logic [BE_W-1:0]                    ld_be_i,
  output sb_pkg::ld_res_e                    res_o,
  output logic [DATA_W-1:0]                  data_o
);
  import sb_pkg::*;

  logic             found;
  logic [IDX_W-1:0] sel;

  // walk oldest to youngest; last match wins
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [IDX_W-1:0] ix;
      ix = IDX_W'(ring_idx(int'(head_i), a, DEPTH));
      if (vld_i[ix] && waddr_i[ix] == ld_addr_i && |(be_i[ix] & ld_be_i)) begin
        found = 1'b1;
        sel   = ix;
      end
    end
  end

  always_comb begin
    res_o  = LD_MISS;
    data_o = '0;
    if (ld_valid_i && found) begin
      if (|(ld_be_i & ~be_i[sel])) res_o = LD_STALL;
      else begin
        res_o = LD_HIT;
        for (int b = 0; b < BE_W; b++)
          if (ld_be_i[b]) data_o[8*b +: 8] = data_i[sel][8*b +: 8];
      end
    end
  end

endmodule

// File: rtl/sb_barrier.sv
module sb_barrier (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bar_i,
  input  logic empty_i,
  output logic block_o,
  output logic done_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= bar_i || (pend_q && !empty_i);
  end

  assign block_o = pend_q && !empty_i;
  assign done_o  = pend_q && empty_i;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !bar_i |=> !done_o)
    else $error("done held"); // R10

endmodule

// File: rtl/store_buffer_fwd.sv
module store_buffer_fwd #(
  parameter int LINE_W = 26,
  parameter int OFS_W  = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int N_PEER = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              st_valid_i,
  input  logic [LINE_W+OFS_W-1:0]           st_addr_i,
  input  logic [DATA_W-1:0]                 st_data_i,
  input  logic [DATA_W/8-1:0]               st_be_i,
  input  logic                              st_excl_i,
  output logic                              st_ready_o,
  output logic                              rdinv_valid_o,
  output logic [LINE_W-1:0]                 rdinv_line_o,
  output logic [$clog2(DEPTH)-1:0]          rdinv_idx_o,
  input  logic [N_PEER-1:0]                 ack_vld_i,
  input  logic [N_PEER*$clog2(DEPTH)-1:0]   ack_idx_i,
  output logic                              cwr_valid_o,
  output logic [LINE_W+OFS_W-1:0]           cwr_addr_o,
  output logic [DATA_W-1:0]                 cwr_data_o,
  output logic [DATA_W/8-1:0]               cwr_be_o,
  input  logic                              ld_valid_i,
  input  logic [LINE_W+OFS_W-1:0]           ld_addr_i,
  input  logic [DATA_W/8-1:0]               ld_be_i,
  output logic                              ld_hit_o,
  output logic                              ld_stall_o,
  output logic [DATA_W-1:0]                 ld_data_o,
  input  logic                              bar_i,
  output logic                              bar_done_o
);
  import sb_pkg::*;

  localparam int WA_W  = LINE_W + OFS_W;
  localparam int BE_W  = DATA_W / 8;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(N_PEER + 1);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] head_q, tail_q;
  logic [OCC_W-1:0] occ_q;
  logic             empty, full, bar_block;
  logic             acc, direct, alloc, commit;

  logic [DEPTH-1:0]              ent_vld;
  logic [DEPTH-1:0][WA_W-1:0]    ent_waddr;
  logic [DEPTH-1:0][DATA_W-1:0]  ent_data;
  logic [DEPTH-1:0][BE_W-1:0]    ent_be;
  logic [DEPTH-1:0][CNT_W-1:0]   ent_acks;
  ld_res_e                       ld_res;

  assign empty = occ_q == '0;
  assign full  = occ_q == OCC_W'(DEPTH);

  assign st_ready_o = !bar_block && (st_excl_i || !full);
  assign acc        = st_valid_i && st_ready_o;
  assign direct     = acc && st_excl_i;
  assign alloc      = acc && !st_excl_i;
  // direct store owns the cache port; head waits one cycle
  assign commit     = ent_vld[head_q] && ent_acks[head_q] == '0 && !direct;

  assign rdinv_valid_o = alloc;
  assign rdinv_line_o  = st_addr_i[WA_W-1:OFS_W];
  assign rdinv_idx_o   = tail_q;

  assign cwr_valid_o = direct || commit;
  assign cwr_addr_o  = direct ? st_addr_i : ent_waddr[head_q];
  assign cwr_data_o  = direct ? st_data_i : ent_data[head_q];
  assign cwr_be_o    = direct ? st_be_i   : ent_be[head_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (alloc)  tail_q <= (tail_q == IDX_W'(DEPTH-1)) ? '0 : tail_q + IDX_W'(1);
      if (commit) head_q <= (head_q == IDX_W'(DEPTH-1)) ? '0 : head_q + IDX_W'(1);
      occ_q <= occ_q + OCC_W'(alloc) - OCC_W'(commit);
    end
  end

  sb_entries #(
    .WA_W(WA_W), .DATA_W(DATA_W), .BE_W(BE_W), .DEPTH(DEPTH),
    .IDX_W(IDX_W), .N_PEER(N_PEER), .CNT_W(CNT_W)
  ) u_entries (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .alloc_i(alloc), .alloc_idx_i(tail_q),
    .waddr_i(st_addr_i), .data_i(st_data_i), .be_i(st_be_i),
    .commit_i(commit), .commit_idx_i(head_q),
    .ack_vld_i(ack_vld_i), .ack_idx_i(ack_idx_i),
    .vld_o(ent_vld), .waddr_o(ent_waddr), .data_o(ent_data),
    .be_o(ent_be), .acks_o(ent_acks)
  );

  sb_fwd #(
    .WA_W(WA_W), .DATA_W(DATA_W), .BE_W(BE_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_fwd (
    .vld_i(ent_vld), .waddr_i(ent_waddr), .data_i(ent_data), .be_i(ent_be),
    .head_i(head_q), .ld_valid_i(ld_valid_i), .ld_addr_i(ld_addr_i),
    .ld_be_i(ld_be_i), .res_o(ld_res), .data_o(ld_data_o)
  );

  assign ld_hit_o   = ld_res == LD_HIT;
  assign ld_stall_o = ld_res == LD_STALL;

  sb_barrier u_bar (
    .clk_i(clk_i), .rst_ni(rst_ni), .bar_i(bar_i), .empty_i(empty),
    .block_o(bar_block), .done_o(bar_done_o)
  );

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdinv_valid_o |-> occ_q < OCC_W'(DEPTH))
    else $error("alloc into full queue"); // R9

  AST_BAR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bar_i) && !empty |-> !st_ready_o)
    else $error("store passed barrier"); // R10

  AST_FWD_NEEDS_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_hit_o || ld_stall_o) |-> !empty)
    else $error("forward from empty queue"); // R6

  AST_BYPASS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i && st_ready_o && st_excl_i |-> cwr_valid_o && cwr_addr_o == st_addr_i)
    else $error("exclusive store not written"); // R8

endmodule

// File: tb/sim_store_buffer_fwd.sv
`timescale 1ns/1ps
module sim_store_buffer_fwd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid, st_excl, st_ready;
  logic [29:0] st_addr;
  logic [31:0] st_data;
  logic [3:0]  st_be;
  logic        rdinv_valid;
  logic [25:0] rdinv_line;
  logic [1:0]  rdinv_idx;
  logic [2:0]  ack_vld;
  logic [5:0]  ack_idx;
  logic        cwr_valid;
  logic [29:0] cwr_addr;
  logic [31:0] cwr_data;
  logic [3:0]  cwr_be;
  logic        ld_valid, ld_hit, ld_stall;
  logic [29:0] ld_addr;
  logic [3:0]  ld_be;
  logic [31:0] ld_data;
  logic        bar, bar_done;

  int n_chk = 0;
  int n_err = 0;
  int n_alloc = 0;

  always #10 clk = ~clk;

  store_buffer_fwd u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data),
    .st_be_i(st_be), .st_excl_i(st_excl), .st_ready_o(st_ready),
    .rdinv_valid_o(rdinv_valid), .rdinv_line_o(rdinv_line), .rdinv_idx_o(rdinv_idx),
    .ack_vld_i(ack_vld), .ack_idx_i(ack_idx),
    .cwr_valid_o(cwr_valid), .cwr_addr_o(cwr_addr), .cwr_data_o(cwr_data),
    .cwr_be_o(cwr_be),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_be_i(ld_be),
    .ld_hit_o(ld_hit), .ld_stall_o(ld_stall), .ld_data_o(ld_data),
    .bar_i(bar), .bar_done_o(bar_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    st_valid = 0; st_excl = 0; st_addr = '0; st_data = '0; st_be = '0;
    ack_vld = '0; ack_idx = '0; ld_valid = 0; ld_addr = '0; ld_be = '0; bar = 0;
  endtask

  // start a cycle: inputs change at the falling edge
  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  task automatic set_st(input logic [29:0] a, input logic [31:0] d,
                        input logic [3:0] be, input bit ex);
    st_valid = 1; st_addr = a; st_data = d; st_be = be; st_excl = ex;
  endtask

  task automatic set_ack_all(input logic [1:0] ix);
    ack_vld = 3'b111; ack_idx = {ix, ix, ix};
  endtask

  task automatic chk_cwr(input string req, input bit exp_v,
                         input logic [29:0] a, input logic [31:0] d);
    chk(cwr_valid == exp_v, req, "cwr_valid", 64'(cwr_valid), 64'(exp_v));
    if (exp_v) begin
      chk(cwr_addr == a, req, "cwr_addr", 64'(cwr_addr), 64'(a));
      chk(cwr_data == d, req, "cwr_data", 64'(cwr_data), 64'(d));
    end
  endtask

  // park a store (st_excl=0) and check the request in the same cycle
  task automatic park(input string req, input logic [29:0] a, input logic [31:0] d,
                      input logic [3:0] be, input bit with_ack, input logic [1:0] ack_ix);
    cyc();
    set_st(a, d, be, 1'b0);
    if (with_ack) set_ack_all(ack_ix);
    #2;
    chk(rdinv_valid == 1'b1, req, "rdinv_valid", 64'(rdinv_valid), 64'd1);
    chk(rdinv_line == a[29:4], req, "rdinv_line", 64'(rdinv_line), 64'(a[29:4]));
    chk(rdinv_idx == 2'(n_alloc % 4), req, "rdinv_idx", 64'(rdinv_idx), 64'(n_alloc % 4));
    n_alloc++;
  endtask

  task automatic t_reset();
    #2;
    chk(st_ready == 1'b1, "R1", "st_ready", 64'(st_ready), 64'd1);
    chk(rdinv_valid == 1'b0, "R1", "rdinv_valid", 64'(rdinv_valid), 64'd0);
    chk(cwr_valid == 1'b0, "R1", "cwr_valid", 64'(cwr_valid), 64'd0);
    chk(ld_hit == 1'b0 && ld_stall == 1'b0, "R1", "ld_hit|ld_stall",
        64'({ld_hit, ld_stall}), 64'd0);
    chk(bar_done == 1'b0, "R1", "bar_done", 64'(bar_done), 64'd0);
  endtask

  task automatic t_commit_after_acks();
    logic [29:0] a = 30'h0000_1003;
    park("R2", a, 32'h1111_2222, 4'hF, 0, 0);
    chk_cwr("R2", 0, a, 0);
    for (int p = 0; p < 3; p++) begin
      cyc();
      ack_vld[p] = 1'b1; ack_idx[p*2 +: 2] = 2'd0;
      #2 chk_cwr("R3", 0, a, 0);
    end
    cyc(); #2 chk_cwr("R3", 1, a, 32'h1111_2222);
    cyc(); #2 chk_cwr("R3", 0, a, 0);
  endtask

  task automatic t_order();
    logic [29:0] b = 30'h0000_2001, c = 30'h0000_2002, d = 30'h0000_2005;
    park("R4", b, 32'hB0B0_B0B0, 4'hF, 0, 0);   // slot 1
    park("R4", c, 32'hC0C0_C0C0, 4'hF, 0, 0);   // slot 2
    cyc(); set_ack_all(2'd2); #2 chk_cwr("R5", 0, b, 0);
    cyc(); #2 chk_cwr("R4", 0, b, 0);            // younger ready, older not
    park("R5", d, 32'hD0D0_D0D0, 4'hF, 1, 2'd1); // slot 3 with acks for slot 1
    cyc(); #2 chk_cwr("R4", 1, b, 32'hB0B0_B0B0);
    cyc(); #2 chk_cwr("R4", 1, c, 32'hC0C0_C0C0);
    cyc(); set_ack_all(2'd3); #2 chk_cwr("R5", 0, d, 0);
    cyc(); #2 chk_cwr("R5", 1, d, 32'hD0D0_D0D0);
    cyc(); #2 chk_cwr("R4", 0, d, 0);
  endtask

  task automatic t_forward();
    logic [29:0] x = 30'h0000_3007, y = 30'h0000_3008;
    park("R6", x, 32'hAABB_CCDD, 4'hF, 0, 0);    // slot 0
    park("R6", x, 32'h0000_1122, 4'h3, 0, 0);    // slot 1
    cyc();
    ld_valid = 1; ld_addr = x; ld_be = 4'h3;
    #1 chk(ld_hit && !ld_stall, "R6", "hit young", 64'({ld_hit, ld_stall}), 64'h2);
    chk(ld_data == 32'h0000_1122, "R6", "data young", 64'(ld_data), 64'h1122);
    ld_be = 4'hC;
    #1 chk(ld_hit && !ld_stall, "R6", "hit old", 64'({ld_hit, ld_stall}), 64'h2);
    chk(ld_data == 32'hAABB_0000, "R6", "data old", 64'(ld_data), 64'hAABB0000);
    ld_be = 4'hF;
    #1 chk(!ld_hit && ld_stall, "R7", "partial", 64'({ld_hit, ld_stall}), 64'h1);
    ld_addr = y;
    #1 chk(!ld_hit && !ld_stall, "R11", "miss", 64'({ld_hit, ld_stall}), 64'h0);
    cyc(); set_ack_all(2'd0);
    cyc(); ld_valid = 1; ld_addr = x; ld_be = 4'hF;
    #2 chk_cwr("R7", 1, x, 32'hAABB_CCDD);
    chk(ld_stall == 1'b1, "R7", "stall while slot1 queued", 64'(ld_stall), 64'd1);
    cyc(); set_ack_all(2'd1); ld_valid = 1; ld_addr = x; ld_be = 4'hF;
    #2 chk(ld_stall == 1'b1, "R7", "stall before commit", 64'(ld_stall), 64'd1);
    cyc(); ld_valid = 1; ld_addr = x; ld_be = 4'hF;
    #2 chk_cwr("R7", 1, x, 32'h0000_1122);
    chk(ld_stall == 1'b1, "R7", "stall in commit cycle", 64'(ld_stall), 64'd1);
    cyc(); ld_valid = 1; ld_addr = x; ld_be = 4'hF;
    #2 chk(!ld_stall && !ld_hit, "R7", "released", 64'({ld_hit, ld_stall}), 64'h0);
  endtask

  task automatic t_bypass();
    logic [29:0] p = 30'h0000_4001, q = 30'h0000_4102;
    park("R8", p, 32'h5050_5050, 4'hF, 0, 0);    // slot 2
    cyc(); set_ack_all(2'd2);
    cyc(); set_st(q, 32'h7777_0001, 4'hF, 1'b1);
    #2 chk(st_ready && !rdinv_valid, "R8", "direct accept", 64'({st_ready, rdinv_valid}), 64'h2);
    chk_cwr("R8", 1, q, 32'h7777_0001);
    cyc(); #2 chk_cwr("R8", 1, p, 32'h5050_5050);
    cyc(); #2 chk_cwr("R8", 0, p, 0);
  endtask

  task automatic t_full();
    logic [29:0] r = 30'h0000_5000;
    for (int i = 0; i < 4; i++) park("R9", r + 30'(i), 32'(i + 1), 4'hF, 0, 0);
    cyc(); set_st(r + 30'd9, 32'hFFFF_0000, 4'hF, 1'b0);
    #2 chk(!st_ready && !rdinv_valid, "R9", "full stall", 64'({st_ready, rdinv_valid}), 64'h0);
    st_excl = 1'b1;
    #1 chk(st_ready == 1'b1, "R9", "excl when full", 64'(st_ready), 64'd1);
    chk_cwr("R9", 1, r + 30'd9, 32'hFFFF_0000);
    for (int i = 0; i < 4; i++) begin
      cyc(); set_ack_all(2'((n_alloc - 4 + i) % 4));
    end
    for (int i = 0; i < 5; i++) cyc();
    #2 chk(st_ready == 1'b1, "R9", "drained", 64'(st_ready), 64'd1);
  endtask

  task automatic t_barrier();
    logic [29:0] s = 30'h0000_6003;
    logic [1:0]  sx;
    sx = 2'(n_alloc % 4);
    park("R10", s, 32'h5EED_0001, 4'hF, 0, 0);
    cyc(); bar = 1;
    #2 chk(bar_done == 1'b0, "R10", "done early", 64'(bar_done), 64'd0);
    cyc(); set_st(30'h0000_6100, 32'h1, 4'hF, 1'b1);
    #2 chk(st_ready == 1'b0, "R10", "excl blocked", 64'(st_ready), 64'd0);
    chk_cwr("R10", 0, s, 0);
    cyc(); set_ack_all(sx); set_st(30'h0000_6100, 32'h1, 4'hF, 1'b0);
    #2 chk(st_ready == 1'b0, "R10", "store blocked", 64'(st_ready), 64'd0);
    cyc(); #2 chk_cwr("R10", 1, s, 32'h5EED_0001);
    chk(bar_done == 1'b0 && st_ready == 1'b0, "R10", "still draining",
        64'({bar_done, st_ready}), 64'h0);
    cyc(); #2 chk(bar_done == 1'b1 && st_ready == 1'b1, "R10", "done",
                  64'({bar_done, st_ready}), 64'h3);
    cyc(); #2 chk(bar_done == 1'b0, "R10", "done pulse", 64'(bar_done), 64'd0);
    cyc(); bar = 1;
    cyc(); #2 chk(bar_done == 1'b1, "R10", "empty barrier", 64'(bar_done), 64'd1);
    cyc(); #2 chk(bar_done == 1'b0, "R10", "empty pulse", 64'(bar_done), 64'd0);
  endtask

  bit finished = 0;

  initial begin
    idle();
    #35 rst_n = 1'b1;
    t_reset();
    t_commit_after_acks();
    t_order();
    t_forward();
    t_bypass();
    t_full();
    t_barrier();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule